// File: doc/BRIEF.md
# Firmware Record Stream Loader

This block sits between a byte stream carrying a firmware image and the write port of a processor's program RAM. The image is a chain of records. Each record opens with a four-byte header: a 16-bit load address and a 16-bit payload length, both sent low byte first. The payload bytes follow the header, and the next header starts on the very next byte. The loader walks the chain in stream order. It writes every payload byte to the RAM at an address that starts at the record's load address and steps up by one for each byte.

Input bytes arrive over a valid/ready handshake. The final byte of an image is flagged with `in_last`. A RAM write is offered with `ram_we` and stays on the port until the RAM accepts it with `ram_ready`. While a write waits, no new byte is taken, so back-pressure from the RAM reaches the stream source.

The block signals the end of an image in one of two ways. If the image ends exactly on a record boundary, it raises a one-cycle completion pulse and is ready at once for another image. If the image ends part-way through a header or a payload, it raises a sticky error flag and stops accepting input until reset.

Top module: `fw_record_loader`

## Requirements
- R1: The four header bytes of a record are taken in this order: load address low byte, load address high byte, length low byte, length high byte.
- R2: Payload byte i of a record (counting from 0) is written with `ram_wdata` equal to that byte and `ram_addr` equal to the load address plus i, modulo 2^16.
- R3: A record whose length is 0 makes no RAM write, and the byte after its header is taken as the first byte of the next header.
- R4: Records are processed back to back in stream order, with no gap bytes between one record's payload and the next header.
- R5: While `ram_we` is high and `ram_ready` is low, `ram_we`, `ram_addr` and `ram_wdata` hold their values. `in_ready` is low in that state, so no payload byte is lost.
- R6: When a byte flagged `in_last` completes a record, `load_done` is high for exactly one cycle, after which a new image is accepted. `load_done` and `load_err` are never high together.
- R7: When a byte flagged `in_last` leaves a header or a payload unfinished, `load_err` rises and stays high until reset. From then on `in_ready` is low, and any bytes still offered produce no RAM write.
- R8: After reset, `in_ready` is high and `ram_we`, `load_done` and `load_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stream byte is offered |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | The offered byte is the final byte of the image |
| in_ready | output | 1 | The loader takes the offered byte at this edge |
| ram_we | output | 1 | A RAM write is pending |
| ram_addr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_ready | input | 1 | The RAM accepts the pending write at this edge |
| load_done | output | 1 | One-cycle pulse: the image ended on a record boundary |
| load_err | output | 1 | Sticky flag: the image ended inside a record |

## Verification
The main image combines several record types:
- a record with a length of 3 whose swapped-byte reading would be 768, so any byte-order error in the header changes the write count;
- a record that crosses a 256-byte page, which exposes any carry error in the address counter;
- a zero-length record in the middle of the chain;
- a record that starts at the top address, which checks wrap-around to zero.

A second image follows directly, which confirms that the loader restarts after `load_done`. The RAM throttles the main image in a repeating pattern, so every stall is checked for a stable write port and a complete, ordered write log. Separate runs end an image inside a header and inside a payload, and a third run sends an image made only of a zero-length record. Together these separate the error path from the completion path.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_PAY  = 2'd1,
    ST_HALT = 2'd2
  } fwl_state_e;
endpackage

// File: rtl/fwl_parser.sv
module fwl_parser
  import fwl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_i,
  input  logic [7:0]        byte_i,
  input  logic              last_i,
  output logic              pay_stb_o,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic [7:0]        pay_data_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int HDR_W     = ADDR_W + LEN_W;
  localparam int HDR_BYTES = HDR_W / 8;
  localparam int IDX_W     = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;

  fwl_state_e        state;
  logic [HDR_W-1:0]  hdr_sr;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;

  logic [HDR_W-1:0]  hdr_full;
  logic [LEN_W-1:0]  new_len;
  logic              hdr_end, pay_end, at_boundary;

  // little-endian assembly: each new byte enters at the top and shifts down
  assign hdr_full    = {byte_i, hdr_sr[HDR_W-1:8]};
  assign new_len     = hdr_full[HDR_W-1:ADDR_W];
  assign hdr_end     = (idx == IDX_W'(HDR_BYTES - 1));
  assign pay_end     = (remain == LEN_W'(1));
  assign at_boundary = ((state == ST_HDR) && hdr_end && (new_len == '0)) ||
                       ((state == ST_PAY) && pay_end);

  assign pay_stb_o  = acc_i && (state == ST_PAY);
  assign pay_addr_o = cur_addr;
  assign pay_data_o = byte_i;
  assign err_o      = (state == ST_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HDR;
      hdr_sr   <= '0;
      idx      <= '0;
      cur_addr <= '0;
      remain   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (acc_i) begin
        case (state)
          ST_HDR: begin
            hdr_sr <= hdr_full;
            if (hdr_end) begin
              idx      <= '0;
              cur_addr <= hdr_full[ADDR_W-1:0];
              remain   <= new_len;
              if (new_len != '0) state <= ST_PAY;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          ST_PAY: begin
            cur_addr <= cur_addr + 1'b1;
            remain   <= remain - 1'b1;
            if (pay_end) state <= ST_HDR;
          end
          default: state <= ST_HALT;
        endcase
        if (last_i) begin
          if (at_boundary) done_o <= 1'b1;
          else begin
            state <= ST_HALT;
            idx   <= '0;
          end
        end
      end
    end
  end

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_hdr_align_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAY) |-> (idx == '0));
endmodule

// File: rtl/fwl_wr_stage.sv
module fwl_wr_stage #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              ram_ready_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_we_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
    end else if (load_i) begin
      ram_we_o    <= 1'b1;
      ram_addr_o  <= addr_i;
      ram_wdata_o <= data_i;
    end else if (ram_ready_i) begin
      ram_we_o <= 1'b0;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ram_we_o && !ram_ready_i) |=>
      (ram_we_o && $stable(ram_addr_o) && $stable(ram_wdata_o)));
endmodule

// File: rtl/fw_record_loader.sv
module fw_record_loader #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              ram_ready,
  output logic              load_done,
  output logic              load_err
);
  logic              acc, pay_stb;
  logic [ADDR_W-1:0] pay_addr;
  logic [7:0]        pay_data;

  assign in_ready = !load_err && (!ram_we || ram_ready);
  assign acc      = in_valid && in_ready;

  fwl_parser #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_parser (
    .clk       (clk),
    .rst       (rst),
    .acc_i     (acc),
    .byte_i    (in_data),
    .last_i    (in_last),
    .pay_stb_o (pay_stb),
    .pay_addr_o(pay_addr),
    .pay_data_o(pay_data),
    .done_o    (load_done),
    .err_o     (load_err)
  );

  fwl_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (pay_stb),
    .addr_i     (pay_addr),
    .data_i     (pay_data),
    .ram_ready_i(ram_ready),
    .ram_we_o   (ram_we),
    .ram_addr_o (ram_addr),
    .ram_wdata_o(ram_wdata)
  );

  assert_no_drop_R5: assert property (@(posedge clk) disable iff (rst)
    pay_stb |-> (!ram_we || ram_ready));
  assert_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(load_done && load_err));
  assert_err_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    load_err |-> !in_ready);
endmodule

// File: tb/fw_record_loader_tb_top.sv
module fw_record_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSTREAM = 29;
  localparam int NEXP = 9;

  // {last, byte}
  localparam logic [8:0] STREAM [0:NSTREAM-1] = '{
    9'h034, 9'h012, 9'h003, 9'h000, 9'h0AA, 9'h0BB, 9'h0CC,
    9'h0FE, 9'h001, 9'h003, 9'h000, 9'h011, 9'h022, 9'h033,
    9'h000, 9'h050, 9'h000, 9'h000,
    9'h0FF, 9'h0FF, 9'h002, 9'h000, 9'h044, 9'h155,
    9'h000, 9'h030, 9'h001, 9'h000, 9'h199
  };
  // {addr, data}
  localparam logic [23:0] EXP [0:NEXP-1] = '{
    24'h1234AA, 24'h1235BB, 24'h1236CC, 24'h01FE11, 24'h01FF22,
    24'h020033, 24'hFFFF44, 24'h000055, 24'h300099
  };

  logic        clk, rst, in_valid, in_last, in_ready;
  logic [7:0]  in_data, ram_wdata;
  logic        ram_we, ram_ready, load_done, load_err;
  logic [15:0] ram_addr;

  int n_chk, n_bad, wcnt, done_cnt, hold_bad, stall_cnt, cyc;
  logic bp_en;
  logic [23:0] wlog [0:31];
  logic        p_we, p_rdy;
  logic [23:0] p_word;

  fw_record_loader dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_ready(ram_ready),
    .load_done(load_done), .load_err(load_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ram_ready <= !bp_en || (cyc % 3 != 0);
    if (rst) begin
      wcnt <= 0; done_cnt <= 0; p_we <= 1'b0; p_rdy <= 1'b1;
    end else begin
      if (ram_we && ram_ready && wcnt < 32) begin
        wlog[wcnt] <= {ram_addr, ram_wdata};
        wcnt <= wcnt + 1;
      end
      if (load_done) done_cnt <= done_cnt + 1;
      if (ram_we && !ram_ready) stall_cnt <= stall_cnt + 1;
      if (p_we && !p_rdy && (!ram_we || {ram_addr, ram_wdata} != p_word))
        hold_bad <= hold_bad + 1;
      p_we <= ram_we; p_rdy <= ram_ready; p_word <= {ram_addr, ram_wdata};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic send(input logic [8:0] w);
    in_valid = 1'b1; in_data = w[7:0]; in_last = w[8];
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; hold_bad = 0; stall_cnt = 0; cyc = 0;
    bp_en = 1'b0; ram_ready = 1'b1;
    do_reset();
    // R8 reset state
    chk("R8 in_ready", in_ready, 1);
    chk("R8 ram_we", ram_we, 0);
    chk("R8 load_done", load_done, 0);
    chk("R8 load_err", load_err, 0);

    // main image plus follow-on image, throttled RAM
    bp_en = 1'b1;
    for (int i = 0; i < NSTREAM; i++) send(STREAM[i]);
    repeat (12) @(negedge clk);
    chk("R3 R4 write count", wcnt, NEXP);
    for (int j = 0; j < NEXP; j++) chk("R1 R2 write word", wlog[j], EXP[j]);
    chk("R6 done pulses", done_cnt, 2);
    chk("R7 no error", load_err, 0);
    chk("R5 held under stall", hold_bad, 0);
    chk("R5 stalls seen", (stall_cnt > 0), 1);
    bp_en = 1'b0;

    // end inside a header
    do_reset();
    send(9'h034); send(9'h012); send(9'h103);
    repeat (3) @(negedge clk);
    chk("R7 err in header", load_err, 1);
    chk("R7 ready low", in_ready, 0);
    chk("R7 no write", wcnt, 0);
    chk("R6 no done", done_cnt, 0);

    // end inside a payload, then bytes offered after the error
    do_reset();
    send(9'h000); send(9'h020); send(9'h002); send(9'h000); send(9'h177);
    repeat (3) @(negedge clk);
    chk("R7 err in payload", load_err, 1);
    chk("R2 partial write count", wcnt, 1);
    chk("R2 partial write word", wlog[0], 24'h200077);
    in_valid = 1'b1; in_data = 8'h5A;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 ignored after err", wcnt, 1);
    chk("R7 err sticky", load_err, 1);

    // image of one zero-length record
    do_reset();
    send(9'h010); send(9'h000); send(9'h000); send(9'h100);
    repeat (3) @(negedge clk);
    chk("R3 zero length no write", wcnt, 0);
    chk("R6 zero length done", done_cnt, 1);
    chk("R6 no err", load_err, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule